// File: doc/BRIEF.md
# Set-Dueling Insertion Policy Selector

This block decides, for every cache access, whether the incoming line should be inserted under the recency-stack policy (LRU insertion) or under the bimodal policy (BIP insertion). A small sample of cache sets is reserved for each policy, and those sets always use their own policy. Misses in the two samples move one shared saturating counter in opposite directions. All remaining sets, the followers, use whichever policy the counter's most significant bit currently favours.

The cache controller presents a set index, a valid strobe and a miss flag for each access. One cycle later the block returns a registered mode bit for that access. The mode is derived from the counter value held before the access's own update. The replacement stacks, the random throttle of the bimodal policy and the tag and data arrays live outside this block. The whole selector state is a 10-bit counter plus two output flops, which is under two bytes.

Top module: `dueling_policy_sel`

## Requirements
- R1: After synchronous reset the counter holds its midpoint 512 (10'b10_0000_0000), `mode_valid` is 0, and follower sets therefore start in BIP mode (`mode_bip` = 1).
- R2: A set whose index bits [9:5] equal bits [4:0] (for example 0, 33, 1023) is a dedicated-LRU set and always gets `mode_bip` = 0, whatever the counter value.
- R3: A set whose index bits [9:5] equal the bitwise complement of bits [4:0] (for example 31, 992) is a dedicated-BIP set and always gets `mode_bip` = 1, whatever the counter value.
- R4: A valid miss in a dedicated-LRU set increments the counter by one.
- R5: A valid miss in a dedicated-BIP set decrements the counter by one.
- R6: A follower set gets `mode_bip` equal to the counter's most significant bit (0 selects LRU insertion, 1 selects BIP insertion).
- R7: Hits in any set, and misses in follower sets, leave the counter unchanged.
- R8: The counter saturates at 1023: further dedicated-LRU misses do not wrap it.
- R9: The counter saturates at 0: further dedicated-BIP misses do not wrap it.
- R10: `mode_valid` and `mode_bip` are registered one cycle after the access. A cycle with `acc_valid` = 0 gives `mode_valid` = 0 and does not change the counter.
- R11: The mode returned for an access uses the counter value before that same access's update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_set | input | 10 | Set index of the access |
| acc_miss | input | 1 | The access missed in the cache |
| mode_valid | output | 1 | Registered: `mode_bip` belongs to last cycle's access |
| mode_bip | output | 1 | Registered insertion mode: 1 = bimodal, 0 = LRU |

## Verification
A mixed vector sequence interleaves hits and misses in both dedicated classes with follower accesses. Following the follower mode through it tells the counter's direction and the exact midpoint crossing apart from a counter that ignores one class. Long runs of same-class misses drive the counter to each rail and past it. A counted walk back then shows whether it saturated or wrapped. Idle cycles that carry a dedicated-class miss flag separate the valid gating from the miss path.

// File: rtl/dueling_pkg.sv
package dueling_pkg;
  typedef enum logic [1:0] {
    CLS_FOLLOW = 2'd0,
    CLS_LRU    = 2'd1,
    CLS_BIP    = 2'd2
  } set_class_e;
endpackage

// File: rtl/dueling_set_classifier.sv
module dueling_set_classifier #(
  parameter int SET_W = 10
) (
  input  logic [SET_W-1:0]         set_idx,
  output dueling_pkg::set_class_e  set_cls
);
  localparam int HALF = SET_W / 2;

  logic [HALF-1:0] upper_bits;
  logic [HALF-1:0] lower_bits;

  generate
    if ((SET_W % 2) == 0) begin : g_even
      assign upper_bits = set_idx[SET_W-1 -: HALF];
      assign lower_bits = set_idx[HALF-1:0];
    end else begin : g_odd
      // the top bit is left out of the sample match for odd widths
      assign upper_bits = set_idx[SET_W-2 -: HALF];
      assign lower_bits = set_idx[HALF-1:0];
    end
  endgenerate

  always_comb begin
    if (upper_bits == lower_bits)
      set_cls = dueling_pkg::CLS_LRU;
    else if (upper_bits == ~lower_bits)
      set_cls = dueling_pkg::CLS_BIP;
    else
      set_cls = dueling_pkg::CLS_FOLLOW;
  end
endmodule

// File: rtl/dueling_sat_counter.sv
module dueling_sat_counter #(
  parameter int CTR_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             up,
  input  logic             down,
  output logic [CTR_W-1:0] count,
  output logic             top_bit
);
  localparam logic [CTR_W-1:0] CMAX = {CTR_W{1'b1}};
  localparam logic [CTR_W-1:0] CMID = CTR_W'(1) << (CTR_W - 1);

  always_ff @(posedge clk) begin
    if (rst)
      count <= CMID;
    else if (up && !down && count != CMAX)
      count <= count + CTR_W'(1);
    else if (down && !up && count != '0)
      count <= count - CTR_W'(1);
  end

  assign top_bit = count[CTR_W-1];

  // R8: no wrap at the top rail
  a_r8_hold_top: assert property (@(posedge clk) disable iff (rst)
    (up && count == CMAX) |=> count == CMAX);
  // R9: no wrap at the bottom rail
  a_r9_hold_bottom: assert property (@(posedge clk) disable iff (rst)
    (down && count == '0) |=> count == '0);
  // R4: single step up below the rail
  a_r4_step_up: assert property (@(posedge clk) disable iff (rst)
    (up && count != CMAX) |=> count == $past(count) + CTR_W'(1));
  // R5: single step down above the rail
  a_r5_step_down: assert property (@(posedge clk) disable iff (rst)
    (down && count != '0) |=> count == $past(count) - CTR_W'(1));
  // R7: no request, no change
  a_r7_idle_stable: assert property (@(posedge clk) disable iff (rst)
    (!up && !down) |=> $stable(count));
endmodule

// File: rtl/dueling_policy_sel.sv
module dueling_policy_sel #(
  parameter int SET_W = 10,
  parameter int CTR_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_valid,
  input  logic [SET_W-1:0] acc_set,
  input  logic             acc_miss,
  output logic             mode_valid,
  output logic             mode_bip
);
  import dueling_pkg::*;

  set_class_e       cls;
  logic             ctr_up;
  logic             ctr_down;
  logic [CTR_W-1:0] ctr_val;
  logic             ctr_msb;
  logic             mode_next;

  dueling_set_classifier #(.SET_W(SET_W)) u_cls (
    .set_idx (acc_set),
    .set_cls (cls)
  );

  assign ctr_up   = acc_valid && acc_miss && (cls == CLS_LRU);
  assign ctr_down = acc_valid && acc_miss && (cls == CLS_BIP);

  dueling_sat_counter #(.CTR_W(CTR_W)) u_ctr (
    .clk     (clk),
    .rst     (rst),
    .up      (ctr_up),
    .down    (ctr_down),
    .count   (ctr_val),
    .top_bit (ctr_msb)
  );

  always_comb begin
    case (cls)
      CLS_LRU: mode_next = 1'b0;
      CLS_BIP: mode_next = 1'b1;
      default: mode_next = ctr_msb;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_valid <= 1'b0;
      mode_bip   <= 1'b1;
    end else begin
      mode_valid <= acc_valid;
      if (acc_valid)
        mode_bip <= mode_next;
    end
  end

  // R10: every access yields a registered mode one cycle later
  a_r10_valid_follows: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> mode_valid);
  // R2: LRU sample sets never get bimodal insertion
  a_r2_lru_sample: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && cls == CLS_LRU) |=> !mode_bip);
  // R3: BIP sample sets always get bimodal insertion
  a_r3_bip_sample: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && cls == CLS_BIP) |=> mode_bip);
  // R6, R11: followers take the pre-update counter MSB
  a_r6_follower_msb: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && cls == CLS_FOLLOW) |=> mode_bip == $past(ctr_val[CTR_W-1]));
  // R7: a hit never moves the counter
  a_r7_hit_no_move: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_miss) |=> $stable(ctr_val));
endmodule

// File: tb/dueling_policy_sel_test.sv
module dueling_policy_sel_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       acc_valid = 1'b0;
  logic [9:0] acc_set = '0;
  logic       acc_miss = 1'b0;
  logic       mode_valid;
  logic       mode_bip;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  dueling_policy_sel uut (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_set(acc_set),
    .acc_miss(acc_miss), .mode_valid(mode_valid), .mode_bip(mode_bip)
  );

  // {set, miss, expected mode_bip}; counter value after each noted
  localparam int NV = 18;
  localparam logic [11:0] VEC [NV] = '{
    {10'd1,   1'b0, 1'b1},  // R1 R6 follower at 512
    {10'd0,   1'b0, 1'b0},  // R2
    {10'd31,  1'b0, 1'b1},  // R3
    {10'd5,   1'b1, 1'b1},  // R7 follower miss
    {10'd33,  1'b1, 1'b0},  // R4 -> 513
    {10'd1,   1'b0, 1'b1},  // R6
    {10'd31,  1'b1, 1'b1},  // R5 -> 512
    {10'd992, 1'b1, 1'b1},  // R5 -> 511
    {10'd2,   1'b0, 1'b0},  // R6 follower LRU
    {10'd31,  1'b0, 1'b1},  // R3 while follower LRU
    {10'd0,   1'b0, 1'b0},  // R2
    {10'd0,   1'b1, 1'b0},  // R4 -> 512
    {10'd3,   1'b0, 1'b1},  // R6
    {10'd1023,1'b1, 1'b0},  // R2 R4 -> 513
    {10'd4,   1'b1, 1'b1},  // R7
    {10'd992, 1'b1, 1'b1},  // R5 -> 512
    {10'd992, 1'b1, 1'b1},  // R11 mode before update -> 511
    {10'd6,   1'b0, 1'b0}   // R6
  };

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic access(input logic [9:0] s, input logic m, input logic exp, input string req);
    acc_valid = 1'b1; acc_set = s; acc_miss = m;
    @(posedge clk); #1;
    acc_valid = 1'b0;
    check(req, mode_valid, 1'b1);
    check(req, mode_bip, exp);
  endtask

  task automatic bulk(input logic [9:0] s, input int n);
    for (int i = 0; i < n; i++) begin
      acc_valid = 1'b1; acc_set = s; acc_miss = 1'b1;
      @(posedge clk); #1;
    end
    acc_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 valid", mode_valid, 1'b0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++)
      access(VEC[i][11:2], VEC[i][1], VEC[i][0], "R2-table");

    // counter now 511; R8 upper saturation
    bulk(10'd0, 512 + 8);                 // 1023, then held
    access(10'd7, 1'b0, 1'b1, "R8 at top");
    bulk(10'd31, 511);                    // 512 if saturated
    access(10'd7, 1'b0, 1'b1, "R8 no wrap");
    bulk(10'd31, 1);                      // 511
    access(10'd7, 1'b0, 1'b0, "R8 back below mid");

    // R9 lower saturation
    bulk(10'd992, 511 + 8);               // 0, then held
    access(10'd8, 1'b0, 1'b0, "R9 at bottom");
    bulk(10'd33, 511);                    // 511 if saturated
    access(10'd8, 1'b0, 1'b0, "R9 no wrap");
    bulk(10'd33, 1);                      // 512
    access(10'd8, 1'b0, 1'b1, "R9 back to mid");

    // R10 idle cycles with miss flag in a BIP sample set
    acc_valid = 1'b0; acc_set = 10'd992; acc_miss = 1'b1;
    repeat (3) begin
      @(posedge clk); #1;
      check("R10 idle valid", mode_valid, 1'b0);
    end
    acc_miss = 1'b0;
    access(10'd9, 1'b0, 1'b1, "R10 idle no update");
    access(10'd992, 1'b1, 1'b1, "R5 after idle");
    access(10'd9, 1'b0, 1'b0, "R5 decrement seen");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule